// File: doc/BRIEF.md
# Trace capture frame arbiter

This block turns a processor's trace events into frames and writes them, one per clock, into a circular on-chip trace buffer. There are two kinds of event. Execution events are breaks in sequential program flow, such as a taken branch, a call, a trap or an interrupt. For each of these the block stores the target address. Host software rebuilds the straight-line instructions in between from the program image. The block counts the plain sequential instructions retired between two breaks and folds that count into the next execution frame, so one frame can cover several instructions. Data events are load and store transactions. Each one becomes a data frame that carries its address and its direction.

Both frame kinds share a single buffer write port. Execution frames always take the port on the edge after their event. Data frames wait in a small holding queue and use the cycles that execution trace leaves free. When the queue is full, new data events are lost. A sticky flag records the loss, and an overflow marker frame carrying the count of dropped events goes into the buffer. Capture runs between a start pulse and a stop pulse. Because of the instruction folding and the queueing, the recorded window and the alignment between execution and data frames are only approximate.

Every frame is 2 + 4 + ADDR_W bits wide. The layout is tag in the top two bits, a 4-bit auxiliary field below it, and the ADDR_W-bit payload at the bottom. Tag codes are 00 idle, 01 execution, 10 data and 11 overflow marker.

Top module: `trace_frame_arbiter`

## Requirements
- R1: After a synchronous reset, wr_en is 0, capturing, overflow and wrapped are 0, and the first frame written lands at buffer address 0.
- R2: capturing rises on the cycle after a start pulse and falls on the cycle after a stop pulse; stop wins when both come together. Events presented while capturing is 0 (including the start cycle itself) produce no frame, and the sequential-instruction count is cleared while capture is off.
- R3: A discontinuity writes an execution frame: tag 01, aux = number of sequential instructions retired since the previous execution frame (0 to 14), payload = target address. A sequential instruction in the same cycle as the discontinuity starts the next count at 1.
- R4: When 15 sequential instructions retire with no discontinuity, an execution frame with tag 01, aux 15 and payload 0 is written and the count restarts from 0.
- R5: A data event writes a data frame: tag 10, aux bit 3 = 1 for a store and 0 for a load, aux bits 2:0 = 0, payload = transaction address. Data frames are written in arrival order.
- R6: An execution frame is written on the clock edge that follows its triggering cycle, whatever else is pending. A data event arriving in the same cycle is written afterwards.
- R7: The data queue holds 4 entries. A data event that arrives while 4 entries are held is dropped, even if an entry leaves in that cycle. The overflow output goes to 1 on the following cycle and stays 1 until reset.
- R8: After a drop, an overflow marker frame is written: tag 11, aux = number of events dropped since the previous marker (saturating at 15), payload 0. The marker is written before queued data frames but after any pending execution frame.
- R9: Consecutive writes use consecutive buffer addresses modulo 16. wrapped becomes 1 after the write to address 15 and stays 1 until reset, and the next write goes to address 0.
- R10: A synchronous reset in the middle of capture clears overflow, wrapped, capture and the queue, and restarts writes at address 0.
- R11: In a cycle without a write, wr_data is all zeros, which is the idle tag 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that begins capture |
| stop | input | 1 | Pulse that ends capture |
| ins_valid | input | 1 | One sequential instruction retired this cycle |
| disc_valid | input | 1 | Program-flow discontinuity this cycle |
| disc_addr | input | ADDR_W | Target address of the discontinuity |
| dat_valid | input | 1 | Load or store transaction this cycle |
| dat_store | input | 1 | 1 = store, 0 = load |
| dat_addr | input | ADDR_W | Transaction address |
| capturing | output | 1 | Capture window open |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | $clog2(BUF_DEPTH) | Buffer write address |
| wr_data | output | ADDR_W+6 | Frame written to the buffer |
| overflow | output | 1 | Sticky: a data event was dropped |
| wrapped | output | 1 | Sticky: the write pointer has wrapped |

## Verification
The bench sweeps every instruction count from 0 to 14 ahead of a discontinuity, and also checks the fold at 15 and the case where a count carries into a discontinuity frame. A counter with an off-by-one error would shift each aux value or emit the saturation frame one instruction early or late. The bench runs back-to-back execution and data events until the queue overflows, then checks the order of the frames: execution frames first, then a marker with a count of two, then the four held data frames in order. A wrong priority would interleave these frames, and a wrong drop rule would lose or duplicate addresses. It also walks the write pointer across the wrap, tests the start/stop corners where stop wins and events in the start cycle are ignored, and resets in the middle of a run. A design that kept stale flags or a stale pointer would fail these checks.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int TAG_W = 2;
  localparam int AUX_W = 4;

  typedef enum logic [TAG_W-1:0] {
    TAG_IDLE = 2'b00,
    TAG_EXEC = 2'b01,
    TAG_DATA = 2'b10,
    TAG_OVFL = 2'b11
  } trc_tag_e;

  // saturating increment of an aux-sized counter
  function automatic logic [AUX_W-1:0] aux_sat_inc(input logic [AUX_W-1:0] v);
    return (v == {AUX_W{1'b1}}) ? v : v + AUX_W'(1);
  endfunction

  // aux field of a data frame: direction in the top bit
  function automatic logic [AUX_W-1:0] data_aux(input logic is_store);
    return {is_store, {(AUX_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/trc_exec_packer.sv
module trc_exec_packer #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              ins_valid,
  input  logic              disc_valid,
  input  logic [ADDR_W-1:0] disc_addr,
  output logic              req,
  output logic [CNT_W-1:0]  aux,
  output logic [ADDR_W-1:0] payload
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic disc_hit, sat_hit;

  assign disc_hit = active & disc_valid;
  assign sat_hit  = active & ins_valid & ~disc_valid & (cnt == CNT_MAX - CNT_W'(1));

  assign req     = disc_hit | sat_hit;
  assign aux     = disc_hit ? cnt : CNT_MAX;
  assign payload = disc_hit ? disc_addr : '0;

  always_ff @(posedge clk) begin
    if (rst || !active)  cnt <= '0;
    else if (disc_hit)   cnt <= ins_valid ? CNT_W'(1) : '0;
    else if (sat_hit)    cnt <= '0;
    else if (ins_valid)  cnt <= cnt + CNT_W'(1);
  end

  assert_cnt_below_max_R4: assert property (@(posedge clk) disable iff (rst)
    cnt != CNT_MAX);
  assert_idle_clears_R2: assert property (@(posedge clk) disable iff (rst)
    !active |=> cnt == '0);
endmodule

// File: rtl/trc_data_fifo.sv
module trc_data_fifo #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              push_store,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic              not_empty,
  output logic              head_store,
  output logic [ADDR_W-1:0] head_addr,
  output logic              drop
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic [ADDR_W-1:0] addr_q  [DEPTH];
  logic              store_q [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr;
  logic [CW-1:0]     count;
  logic              accept, take;

  assign drop       = push & (count == FULL_CNT);
  assign accept     = push & (count != FULL_CNT);
  assign take       = pop & (count != '0);
  assign not_empty  = (count != '0);
  assign head_store = store_q[rd_ptr];
  assign head_addr  = addr_q[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (accept) wr_ptr <= ptr_next(wr_ptr);
      if (take)   rd_ptr <= ptr_next(rd_ptr);
      case ({accept, take})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      addr_q[wr_ptr]  <= push_addr;
      store_q[wr_ptr] <= push_store;
    end
  end

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> not_empty);
endmodule

// File: rtl/trc_buf_writer.sv
module trc_buf_writer
  import trc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BUF_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         exec_req,
  input  logic [AUX_W-1:0]             exec_aux,
  input  logic [ADDR_W-1:0]            exec_payload,
  input  logic                         data_avail,
  input  logic                         data_store,
  input  logic [ADDR_W-1:0]            data_addr,
  input  logic                         drop,
  output logic                         data_pop,
  output logic                         wr_en,
  output logic [$clog2(BUF_DEPTH)-1:0] wr_addr,
  output logic [ADDR_W+5:0]            wr_data,
  output logic                         overflow,
  output logic                         wrapped
);
  localparam int BW = $clog2(BUF_DEPTH);
  localparam int FW = TAG_W + AUX_W + ADDR_W;

  function automatic logic [BW-1:0] slot_next(input logic [BW-1:0] p);
    return (p == BW'(BUF_DEPTH - 1)) ? '0 : p + BW'(1);
  endfunction

  function automatic logic [FW-1:0] frame(input trc_tag_e t,
                                          input logic [AUX_W-1:0] a,
                                          input logic [ADDR_W-1:0] p);
    return {t, a, p};
  endfunction

  logic             mark_pend;
  logic [AUX_W-1:0] mark_cnt;
  logic [BW-1:0]    ptr;
  logic             grant_exec, grant_mark, grant_data, grant_any;
  logic [FW-1:0]    sel_frame;

  assign grant_exec = exec_req;
  assign grant_mark = ~exec_req & mark_pend;
  assign grant_data = ~exec_req & ~mark_pend & data_avail;
  assign grant_any  = grant_exec | grant_mark | grant_data;
  assign data_pop   = grant_data;

  always_comb begin
    if (grant_exec)      sel_frame = frame(TAG_EXEC, exec_aux, exec_payload);
    else if (grant_mark) sel_frame = frame(TAG_OVFL, mark_cnt, '0);
    else if (grant_data) sel_frame = frame(TAG_DATA, data_aux(data_store), data_addr);
    else                 sel_frame = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_pend <= 1'b0;
      mark_cnt  <= '0;
      overflow  <= 1'b0;
    end else begin
      if (drop) overflow <= 1'b1;
      if (grant_mark) begin
        mark_pend <= drop;
        mark_cnt  <= drop ? AUX_W'(1) : '0;
      end else if (drop) begin
        mark_pend <= 1'b1;
        mark_cnt  <= aux_sat_inc(mark_cnt);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr     <= '0;
      wrapped <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= grant_any;
      wr_addr <= ptr;
      wr_data <= sel_frame;
      if (grant_any) begin
        ptr <= slot_next(ptr);
        if (ptr == BW'(BUF_DEPTH - 1)) wrapped <= 1'b1;
      end
    end
  end

  assert_exec_first_R6: assert property (@(posedge clk) disable iff (rst)
    exec_req |=> wr_en && wr_data[FW-1 -: TAG_W] == TAG_EXEC);
  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (rst)
    drop |=> overflow);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  assert_wrap_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    wrapped |=> wrapped);
  assert_addr_step_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en) && !$past(rst)) |-> wr_addr == slot_next($past(wr_addr)));
  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !wr_en |-> wr_data == '0);
endmodule

// File: rtl/trace_frame_arbiter.sv
module trace_frame_arbiter
  import trc_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BUF_DEPTH = 16,
  parameter int DQ_DEPTH  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic                         stop,
  input  logic                         ins_valid,
  input  logic                         disc_valid,
  input  logic [ADDR_W-1:0]            disc_addr,
  input  logic                         dat_valid,
  input  logic                         dat_store,
  input  logic [ADDR_W-1:0]            dat_addr,
  output logic                         capturing,
  output logic                         wr_en,
  output logic [$clog2(BUF_DEPTH)-1:0] wr_addr,
  output logic [ADDR_W+5:0]            wr_data,
  output logic                         overflow,
  output logic                         wrapped
);
  logic              exec_req;
  logic [AUX_W-1:0]  exec_aux;
  logic [ADDR_W-1:0] exec_payload;
  logic              q_push, q_pop, q_avail, q_store, q_drop;
  logic [ADDR_W-1:0] q_addr;

  always_ff @(posedge clk) begin
    if (rst)        capturing <= 1'b0;
    else if (stop)  capturing <= 1'b0;
    else if (start) capturing <= 1'b1;
  end

  assign q_push = capturing & dat_valid;

  trc_exec_packer #(.ADDR_W(ADDR_W), .CNT_W(AUX_W)) i_packer (
    .clk(clk), .rst(rst), .active(capturing),
    .ins_valid(ins_valid), .disc_valid(disc_valid), .disc_addr(disc_addr),
    .req(exec_req), .aux(exec_aux), .payload(exec_payload)
  );

  trc_data_fifo #(.ADDR_W(ADDR_W), .DEPTH(DQ_DEPTH)) i_fifo (
    .clk(clk), .rst(rst),
    .push(q_push), .push_store(dat_store), .push_addr(dat_addr),
    .pop(q_pop), .not_empty(q_avail), .head_store(q_store), .head_addr(q_addr),
    .drop(q_drop)
  );

  trc_buf_writer #(.ADDR_W(ADDR_W), .BUF_DEPTH(BUF_DEPTH)) i_writer (
    .clk(clk), .rst(rst),
    .exec_req(exec_req), .exec_aux(exec_aux), .exec_payload(exec_payload),
    .data_avail(q_avail), .data_store(q_store), .data_addr(q_addr),
    .drop(q_drop), .data_pop(q_pop),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .overflow(overflow), .wrapped(wrapped)
  );

  assert_stop_wins_R2: assert property (@(posedge clk) disable iff (rst)
    stop |=> !capturing);
  assert_no_frame_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!capturing && !q_avail && !$past(q_drop)) |=> !wr_en || wr_data[ADDR_W+5 -: 2] == 2'b11);
endmodule

// File: tb/test_trace_frame_arbiter.sv
`timescale 1ns/1ps
module test_trace_frame_arbiter;
  localparam int AW = 16;

  logic clk = 0, rst = 1, start = 0, stop = 0;
  logic ins_valid = 0, disc_valid = 0, dat_valid = 0, dat_store = 0;
  logic [AW-1:0] disc_addr = '0, dat_addr = '0;
  logic capturing, wr_en, overflow, wrapped;
  logic [3:0] wr_addr;
  logic [AW+5:0] wr_data;

  trace_frame_arbiter i_trace_frame_arbiter (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .ins_valid(ins_valid), .disc_valid(disc_valid), .disc_addr(disc_addr),
    .dat_valid(dat_valid), .dat_store(dat_store), .dat_addr(dat_addr),
    .capturing(capturing), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .overflow(overflow), .wrapped(wrapped)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int log_n = 0;
  int log_tag [64];
  int log_aux [64];
  int log_pay [64];
  int log_adr [64];

  always @(posedge clk) begin
    #2;
    if (wr_en && log_n < 64) begin
      log_tag[log_n] = int'(wr_data[21:20]);
      log_aux[log_n] = int'(wr_data[19:16]);
      log_pay[log_n] = int'(wr_data[15:0]);
      log_adr[log_n] = int'(wr_addr);
      log_n++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic want(input string req, input int idx, input int tag, input int aux, input int pay);
    if (idx >= log_n) begin
      checks++; fails++;
      $display("FAIL %s: frame %0d missing, actual count %0d expected > %0d", req, idx, log_n, idx);
    end else begin
      chk(req, log_tag[idx] * 65536 * 16 + log_aux[idx] * 65536 + log_pay[idx],
          tag * 65536 * 16 + aux * 65536 + pay);
    end
  endtask

  task automatic step(input bit i, input bit d, input int da, input bit v, input bit s, input int va);
    ins_valid = i; disc_valid = d; disc_addr = AW'(da);
    dat_valid = v; dat_store = s; dat_addr = AW'(va);
    @(negedge clk);
    ins_valid = 0; disc_valid = 0; dat_valid = 0; dat_store = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; idle(2); rst = 0; idle(1);
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state, R11 idle frame
    chk("R1 wr_en", int'(wr_en), 0);
    chk("R1 capturing", int'(capturing), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 wrapped", int'(wrapped), 0);
    chk("R11 idle data", int'(wr_data), 0);

    // R2 events before start, and in the start cycle, are ignored
    log_n = 0;
    step(1, 1, 16'h1234, 1, 1, 16'h4321);
    start = 1; step(0, 1, 16'h2222, 1, 0, 16'h3333); start = 0;
    idle(6);
    chk("R2 ignored events", log_n, 0);
    chk("R2 capture on", int'(capturing), 1);

    // R3 sweep of counts 0..14 before a discontinuity; first write at slot 0 (R1)
    log_n = 0;
    for (int n = 0; n < 15; n++) begin
      for (int k = 0; k < n; k++) step(1, 0, 0, 0, 0, 0);
      step(0, 1, 16'h0100 + n, 0, 0, 0);
    end
    idle(3);
    for (int n = 0; n < 15; n++) want("R3 count sweep", n, 1, n, 16'h0100 + n);
    chk("R1 first slot", log_adr[0], 0);

    // R4 saturation, then carry into a discontinuity frame; R3 same-cycle restart
    log_n = 0;
    for (int k = 0; k < 20; k++) step(1, 0, 0, 0, 0, 0);
    step(1, 1, 16'hBEEF, 0, 0, 0);
    step(0, 1, 16'hCAFE, 0, 0, 0);
    idle(3);
    want("R4 saturation frame", 0, 1, 15, 0);
    want("R4 remainder count", 1, 1, 5, 16'hBEEF);
    want("R3 same-cycle restart", 2, 1, 1, 16'hCAFE);
    chk("R4 frame total", log_n, 3);

    // R5 data frames, spaced and back to back
    log_n = 0;
    for (int k = 0; k < 6; k++) begin
      step(0, 0, 0, 1, k[0], 16'h0A00 + k);
      if (k < 3) idle(2);
    end
    idle(6);
    for (int k = 0; k < 6; k++) want("R5 data frame", k, 2, k[0] ? 8 : 0, 16'h0A00 + k);
    chk("R11 idle after drain", int'(wr_data), 0);

    // R6 priority: same-cycle exec and data
    log_n = 0;
    step(0, 1, 16'h7000, 1, 1, 16'h7001);
    idle(4);
    want("R6 exec first", 0, 1, 0, 16'h7000);
    want("R6 data second", 1, 2, 8, 16'h7001);

    // R7/R8 overflow: exec every cycle hogs the port
    log_n = 0;
    chk("R7 overflow low before", int'(overflow), 0);
    for (int k = 0; k < 6; k++) step(0, 1, 16'h5000 + k, 1, 0, 16'h6000 + k);
    chk("R7 overflow set", int'(overflow), 1);
    idle(8);
    for (int k = 0; k < 6; k++) want("R6 exec burst", k, 1, 0, 16'h5000 + k);
    want("R8 marker", 6, 3, 2, 0);
    for (int k = 0; k < 4; k++) want("R7 kept data", 7 + k, 2, 0, 16'h6000 + k);
    chk("R7 drop count", log_n, 11);
    chk("R7 overflow sticky", int'(overflow), 1);

    // R2 stop wins, count cleared while off
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    start = 1; stop = 1; @(negedge clk); start = 0; stop = 0;
    chk("R2 stop wins", int'(capturing), 0);
    log_n = 0;
    step(1, 1, 16'h0909, 1, 0, 16'h0808);
    idle(3);
    chk("R2 ignored while off", log_n, 0);
    pulse_start();
    step(0, 1, 16'h0055, 0, 0, 0);
    idle(3);
    want("R2 count cleared", 0, 1, 0, 16'h0055);

    // R10 mid-run reset, R9 wrap
    do_reset();
    chk("R10 overflow cleared", int'(overflow), 0);
    chk("R10 capture cleared", int'(capturing), 0);
    pulse_start();
    log_n = 0;
    for (int k = 0; k < 15; k++) step(0, 1, k, 0, 0, 0);
    idle(2);
    chk("R9 not yet wrapped", int'(wrapped), 0);
    for (int k = 0; k < 15; k++) chk("R10 R9 slot order", log_adr[k], k);
    step(0, 1, 15, 0, 0, 0);
    idle(1);
    chk("R9 wrapped set", int'(wrapped), 1);
    chk("R9 last slot", log_adr[15], 15);
    step(0, 1, 16, 0, 0, 0);
    idle(1);
    chk("R9 back to zero", log_adr[16], 0);
    chk("R9 wrapped sticky", int'(wrapped), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule